// File: doc/BRIEF.md
# Sub-Word Memory Lane Aligner

This block sits between a load/store unit and a local store made of 64-bit words. Each request carries a byte address, a width code for 1, 2, 4 or 8 bytes, and store data for writes. The block splits the address into a word index and a byte offset within the word. A load picks the addressed bytes out of the word and returns them zero-extended. A store writes the addressed bytes into the word and leaves the other bytes unchanged.

Byte lanes are numbered big-endian. Offset 0 is the most significant byte of the word. For a field of `w` bytes at offset `o`, the shift is `(8 - w - o) * 8` bits and the mask is `w * 8` ones. If the offset is not a multiple of the width, the request is not performed and the block returns an error response instead.

A load answers one cycle after it is accepted. A store is a read-modify-write that takes two cycles. `busy` is high during the write cycle, and any request presented while `busy` is high is ignored. A word that has never been written reads as zero.

Top module: `lane_aligner`

## Requirements
- R1: The word index is `req_addr >> 3` and the byte offset is `req_addr[2:0]`. An access changes or reads only the word at that index.
- R2: A request whose offset is not a multiple of its width returns `rsp_valid=1`, `rsp_err=1` and `rsp_rdata=0` one cycle after acceptance. It leaves memory unchanged and does not raise `busy`.
- R3: The width code `req_size` selects 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes and 3 = 8 bytes. A load returns the `w` bytes starting at offset `o`, where offset 0 is the most significant byte of the word. The result is right-justified and zero-extended to 64 bits.
- R4: A store narrower than 8 bytes replaces only the addressed bytes. Every other byte of the word keeps its old value.
- R5: For a store, bits of `req_wdata` above the access width are ignored.
- R6: An 8-byte store at offset 0 replaces the whole word.
- R7: After reset, `busy=0` and `rsp_valid=0`, and every word reads as zero until it is written.
- R8: A legal store drives `busy` high for exactly the one cycle after acceptance, with `rsp_valid` low in that cycle. In the following cycle `rsp_valid=1`, `rsp_err=0`, `rsp_rdata=0` and `busy=0`. The new data is visible to the next accepted request.
- R9: A request presented while `busy` is high is not accepted. It produces no response and no memory change.
- R10: A legal load returns `rsp_valid=1`, `rsp_err=0` one cycle after acceptance. `rsp_valid` is a single-cycle pulse for each accepted request, so loads can be issued on back-to-back cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W (7) | Byte address |
| req_size | input | 2 | Width code: log2 of the byte count |
| req_wdata | input | 64 | Store data, right-justified |
| busy | output | 1 | Store write cycle in progress; requests are ignored |
| rsp_valid | output | 1 | Response pulse |
| rsp_err | output | 1 | Misaligned request, not performed |
| rsp_rdata | output | 64 | Load result, zero-extended |

## Verification
The bench fills a word with distinct byte values and reads every lane at every width. A design with the lane order reversed, or with the shift off by a byte, returns the wrong byte and fails there. Partial stores are sent with junk in the upper bits of the store data. An unmasked or mis-shifted merge would then corrupt the neighbouring bytes, which a full-word read-back shows. Misaligned requests are followed by a read of the target word, so an error that still wrote memory is caught. A second store is held on the bus during the busy cycle, so a design that accepted it would alter another word or emit an extra response.

// File: rtl/lane_pkg.sv
`timescale 1ns/1ps
package lane_pkg;

   // Access width code: log2 of the number of bytes moved.
   typedef enum logic [1:0] {
      SZ_BYTE  = 2'd0,
      SZ_HALF  = 2'd1,
      SZ_WORD  = 2'd2,
      SZ_DWORD = 2'd3
   } lane_size_e;

   typedef enum logic {
      ST_IDLE  = 1'b0,
      ST_MERGE = 1'b1
   } lane_state_e;

   function automatic int unsigned size_to_bytes(input logic [1:0] code);
      return 32'd1 << code;
   endfunction

endpackage

// File: rtl/lane_addr_split.sv
`timescale 1ns/1ps
module lane_addr_split
   import lane_pkg::*;
#(
   parameter int ADDR_W     = 7,
   parameter int WORD_BYTES = 8,
   localparam int OFF_W  = $clog2(WORD_BYTES),
   localparam int IDX_W  = ADDR_W - OFF_W,
   localparam int DATA_W = WORD_BYTES * 8,
   localparam int SH_W   = $clog2(DATA_W)
) (
   input  logic [ADDR_W-1:0]     addr,
   input  logic [1:0]            size,
   output logic [IDX_W-1:0]      idx,
   output logic [OFF_W-1:0]      off,
   output logic                  legal,
   output logic [SH_W-1:0]       shift_bits,
   output logic [DATA_W-1:0]     width_mask,
   output logic [WORD_BYTES-1:0] lane_en
);

   int unsigned nbytes;
   int unsigned off_i;

   assign idx = addr[ADDR_W-1:OFF_W];
   assign off = addr[OFF_W-1:0];

   always_comb begin
      nbytes = size_to_bytes(size);
      off_i  = 32'(off);
      legal  = (nbytes <= 32'(WORD_BYTES)) && ((off_i & (nbytes - 32'd1)) == 32'd0);
      if (legal)
         shift_bits = SH_W'((32'(WORD_BYTES) - nbytes - off_i) * 32'd8);
      else
         shift_bits = '0;
      for (int b = 0; b < WORD_BYTES; b++) begin
         width_mask[b*8 +: 8] = (32'(b) < nbytes) ? 8'hFF : 8'h00;
         // lane b counts from the most significant byte of the word
         lane_en[b] = legal && (32'(b) >= off_i) && (32'(b) < off_i + nbytes);
      end
   end

endmodule

// File: rtl/lane_extract.sv
`timescale 1ns/1ps
module lane_extract #(
   parameter int WORD_BYTES = 8,
   localparam int DATA_W = WORD_BYTES * 8,
   localparam int SH_W   = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] word,
   input  logic [SH_W-1:0]   shift_bits,
   input  logic [DATA_W-1:0] width_mask,
   output logic [DATA_W-1:0] data
);

   logic [DATA_W-1:0] shifted;

   assign shifted = word >> shift_bits;
   assign data    = shifted & width_mask;

endmodule

// File: rtl/lane_merge.sv
`timescale 1ns/1ps
module lane_merge #(
   parameter int WORD_BYTES = 8,
   localparam int DATA_W = WORD_BYTES * 8,
   localparam int SH_W   = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0]     old_word,
   input  logic [DATA_W-1:0]     wdata,
   input  logic [SH_W-1:0]       shift_bits,
   input  logic [DATA_W-1:0]     width_mask,
   input  logic [WORD_BYTES-1:0] lane_en,
   output logic [DATA_W-1:0]     new_word
);

   logic [DATA_W-1:0] trimmed;
   logic [DATA_W-1:0] placed;

   // Trim to the access width first so stray upper bits never reach a neighbour.
   assign trimmed = wdata & width_mask;
   assign placed  = trimmed << shift_bits;

   for (genvar i = 0; i < WORD_BYTES; i++) begin : g_lane
      localparam int POS = (WORD_BYTES - 1 - i) * 8;
      assign new_word[POS +: 8] = lane_en[i] ? placed[POS +: 8] : old_word[POS +: 8];
   end

endmodule

// File: rtl/lane_word_bank.sv
`timescale 1ns/1ps
module lane_word_bank #(
   parameter int DATA_W            = 64,
   parameter int IDX_W             = 4,
   parameter bit USE_WRITTEN_FLAGS = 1'b1,
   localparam int DEPTH = 1 << IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data
);

   if (USE_WRITTEN_FLAGS) begin : g_flags
      // Array without reset; a per-word flag makes unwritten words read as zero.
      logic [DATA_W-1:0] mem [DEPTH];
      logic [DEPTH-1:0]  written;

      always_ff @(posedge clk) begin
         if (wr_en) mem[wr_idx] <= wr_data;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     written <= '0;
         else if (wr_en) written[wr_idx] <= 1'b1;
      end

      assign rd_data = written[rd_idx] ? mem[rd_idx] : '0;
   end else begin : g_clear
      // Every word is cleared on reset.
      logic [DATA_W-1:0] mem [DEPTH];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int w = 0; w < DEPTH; w++) mem[w] <= '0;
         end else if (wr_en) begin
            mem[wr_idx] <= wr_data;
         end
      end

      assign rd_data = mem[rd_idx];
   end

endmodule

// File: rtl/lane_aligner.sv
`timescale 1ns/1ps
module lane_aligner
   import lane_pkg::*;
#(
   parameter int ADDR_W            = 7,
   parameter int WORD_BYTES        = 8,
   parameter bit USE_WRITTEN_FLAGS = 1'b1,
   localparam int OFF_W  = $clog2(WORD_BYTES),
   localparam int IDX_W  = ADDR_W - OFF_W,
   localparam int DATA_W = WORD_BYTES * 8,
   localparam int SH_W   = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [1:0]        req_size,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              busy,
   output logic              rsp_valid,
   output logic              rsp_err,
   output logic [DATA_W-1:0] rsp_rdata
);

   if (WORD_BYTES != 2 && WORD_BYTES != 4 && WORD_BYTES != 8) begin : g_bad_word
      $error("lane_aligner: WORD_BYTES must be 2, 4 or 8");
   end
   if (IDX_W < 1 || IDX_W > 12) begin : g_bad_addr
      $error("lane_aligner: ADDR_W must leave 1 to 12 word-index bits");
   end

   lane_state_e       state;
   logic [ADDR_W-1:0] hold_addr;
   logic [1:0]        hold_size;
   logic [DATA_W-1:0] hold_wdata;

   logic [ADDR_W-1:0]     cur_addr;
   logic [1:0]            cur_size;
   logic [IDX_W-1:0]      cur_idx;
   logic [OFF_W-1:0]      cur_off;
   logic                  cur_legal;
   logic [SH_W-1:0]       cur_shift;
   logic [DATA_W-1:0]     cur_wmask;
   logic [WORD_BYTES-1:0] cur_lanes;
   logic [DATA_W-1:0]     bank_rd;
   logic [DATA_W-1:0]     load_val;
   logic [DATA_W-1:0]     merged;
   logic                  accept;

   assign busy     = (state == ST_MERGE);
   assign accept   = req_valid && !busy;
   assign cur_addr = busy ? hold_addr : req_addr;
   assign cur_size = busy ? hold_size : req_size;

   lane_addr_split #(.ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES)) u_split (
      .addr       (cur_addr),
      .size       (cur_size),
      .idx        (cur_idx),
      .off        (cur_off),
      .legal      (cur_legal),
      .shift_bits (cur_shift),
      .width_mask (cur_wmask),
      .lane_en    (cur_lanes)
   );

   lane_word_bank #(
      .DATA_W(DATA_W), .IDX_W(IDX_W), .USE_WRITTEN_FLAGS(USE_WRITTEN_FLAGS)
   ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_idx  (cur_idx),
      .rd_data (bank_rd),
      .wr_en   (busy),
      .wr_idx  (cur_idx),
      .wr_data (merged)
   );

   lane_extract #(.WORD_BYTES(WORD_BYTES)) u_extract (
      .word       (bank_rd),
      .shift_bits (cur_shift),
      .width_mask (cur_wmask),
      .data       (load_val)
   );

   lane_merge #(.WORD_BYTES(WORD_BYTES)) u_merge (
      .old_word   (bank_rd),
      .wdata      (hold_wdata),
      .shift_bits (cur_shift),
      .width_mask (cur_wmask),
      .lane_en    (cur_lanes),
      .new_word   (merged)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         hold_addr  <= '0;
         hold_size  <= '0;
         hold_wdata <= '0;
         rsp_valid  <= 1'b0;
         rsp_err    <= 1'b0;
         rsp_rdata  <= '0;
      end else begin
         rsp_valid <= 1'b0;
         rsp_err   <= 1'b0;
         rsp_rdata <= '0;
         if (busy) begin
            state     <= ST_IDLE;
            rsp_valid <= 1'b1;
         end else if (accept) begin
            if (!cur_legal) begin
               rsp_valid <= 1'b1;
               rsp_err   <= 1'b1;
            end else if (req_write) begin
               state      <= ST_MERGE;
               hold_addr  <= req_addr;
               hold_size  <= req_size;
               hold_wdata <= req_wdata;
            end else begin
               rsp_valid <= 1'b1;
               rsp_rdata <= load_val;
            end
         end
      end
   end

   // The offset is only used inside the split; keep it observable for the checker path.
   logic unused_off;
   assign unused_off = ^cur_off;

endmodule

// File: rtl/lane_aligner_chk.sv
`timescale 1ns/1ps
module lane_aligner_chk #(
   parameter int ADDR_W     = 7,
   parameter int WORD_BYTES = 8,
   localparam int DATA_W = WORD_BYTES * 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_write,
   input logic [ADDR_W-1:0] req_addr,
   input logic [1:0]        req_size,
   input logic              busy,
   input logic              rsp_valid,
   input logic              rsp_err,
   input logic [DATA_W-1:0] rsp_rdata
);

   int unsigned nb;
   logic        aligned;
   logic        took;

   always_comb begin
      nb      = 32'd1 << req_size;
      aligned = (nb <= 32'(WORD_BYTES)) && ((32'(req_addr) & (nb - 32'd1)) == 32'd0);
   end
   assign took = req_valid && !busy;

   p_busy_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !busy);

   p_store_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (took && req_write && aligned) |=> (busy && !rsp_valid));

   p_store_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (rsp_valid && !rsp_err && rsp_rdata == '0));

   p_misalign_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (took && !aligned) |=> (rsp_valid && rsp_err && !busy && rsp_rdata == '0));

   p_load_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (took && !req_write && aligned) |=> (rsp_valid && !rsp_err && !busy));

   p_byte_zext_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (took && !req_write && aligned && req_size == 2'd0) |=> (rsp_rdata[DATA_W-1:8] == '0));

   p_quiet_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !req_valid) |=> !rsp_valid);

endmodule

bind lane_aligner lane_aligner_chk #(.ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES)) u_chk (.*);

// File: tb/tb_lane_aligner.sv
`timescale 1ns/1ps
module tb_lane_aligner;

   localparam int ADDR_W = 7;
   localparam int NWORDS = 16;
   localparam int LIMIT  = 20000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [6:0]  req_addr = '0;
   logic [1:0]  req_size = '0;
   logic [63:0] req_wdata = '0;
   logic        busy;
   logic        rsp_valid;
   logic        rsp_err;
   logic [63:0] rsp_rdata;

   always #2.5 clk = ~clk;

   lane_aligner #(.ADDR_W(ADDR_W), .WORD_BYTES(8)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
      .busy(busy), .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
   );

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;
   bit finished = 1'b0;
   logic [63:0] ref_mem [NWORDS];

   task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   function automatic logic [63:0] ref_load(input logic [6:0] a, input logic [1:0] s);
      int w   = 1 << s;
      int off = int'(a[2:0]);
      logic [63:0] r = '0;
      for (int b = 0; b < w; b++)
         r[(w-1-b)*8 +: 8] = ref_mem[a[6:3]][(7-(off+b))*8 +: 8];
      return r;
   endfunction

   task automatic ref_store(input logic [6:0] a, input logic [1:0] s, input logic [63:0] d);
      int w   = 1 << s;
      int off = int'(a[2:0]);
      for (int b = 0; b < w; b++)
         ref_mem[a[6:3]][(7-(off+b))*8 +: 8] = d[(w-1-b)*8 +: 8];
   endtask

   // Presents one request for one cycle; returns at the falling edge after acceptance.
   task automatic drive(input logic w, input logic [6:0] a, input logic [1:0] s, input logic [63:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_write = w; req_addr = a; req_size = s; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0; req_wdata = '0;
   endtask

   task automatic do_load(input logic [6:0] a, input logic [1:0] s, input string tag);
      drive(1'b0, a, s, '0);
      chk(tag, "load rsp_valid", 64'(rsp_valid), 64'd1);
      chk(tag, "load rsp_err", 64'(rsp_err), 64'd0);
      chk(tag, "load data", rsp_rdata, ref_load(a, s));
   endtask

   task automatic do_store(input logic [6:0] a, input logic [1:0] s, input logic [63:0] d, input string tag);
      drive(1'b1, a, s, d);
      chk(tag, "store busy", 64'(busy), 64'd1);
      chk(tag, "store early rsp", 64'(rsp_valid), 64'd0);
      ref_store(a, s, d);
      @(negedge clk);
      chk(tag, "store rsp_valid", 64'(rsp_valid), 64'd1);
      chk(tag, "store rsp_err", 64'(rsp_err), 64'd0);
      chk(tag, "store busy clear", 64'(busy), 64'd0);
   endtask

   task automatic do_bad(input logic w, input logic [6:0] a, input logic [1:0] s, input logic [63:0] d);
      drive(w, a, s, d);
      chk("R2", "err rsp_valid", 64'(rsp_valid), 64'd1);
      chk("R2", "err flag", 64'(rsp_err), 64'd1);
      chk("R2", "err busy", 64'(busy), 64'd0);
      chk("R2", "err data", rsp_rdata, 64'd0);
   endtask

   task automatic t_reset;
      chk("R7", "reset busy", 64'(busy), 64'd0);
      chk("R7", "reset rsp_valid", 64'(rsp_valid), 64'd0);
      do_load(7'h18, 2'd3, "R7");
      do_load(7'h7C, 2'd2, "R7");
   endtask

   task automatic t_split;
      do_store(7'h38, 2'd3, 64'hCAFE_F00D_1234_5678, "R6");
      do_load(7'h38, 2'd3, "R6");
      do_load(7'h30, 2'd3, "R1");
      do_load(7'h40, 2'd3, "R1");
      do_load(7'h3C, 2'd2, "R1");
   endtask

   task automatic t_lanes;
      do_store(7'h10, 2'd3, 64'h0011_2233_4455_6677, "R6");
      for (int o = 0; o < 8; o++) do_load(7'(8'h10 + o), 2'd0, "R3");
      for (int o = 0; o < 8; o += 2) do_load(7'(8'h10 + o), 2'd1, "R3");
      do_load(7'h10, 2'd2, "R3");
      do_load(7'h14, 2'd2, "R3");
   endtask

   task automatic t_partial;
      do_store(7'h13, 2'd0, 64'hFFFF_FFFF_FFFF_FFAB, "R5");
      do_load(7'h10, 2'd3, "R4");
      chk("R4", "byte merge", ref_mem[2], 64'h0011_22AB_4455_6677);
      do_store(7'h16, 2'd1, 64'hDEAD_BEEF_0000_1234, "R5");
      do_load(7'h10, 2'd3, "R4");
      do_store(7'h10, 2'd2, 64'h5555_5555_89AB_CDEF, "R5");
      do_load(7'h10, 2'd3, "R4");
      do_load(7'h17, 2'd0, "R3");
   endtask

   task automatic t_misalign;
      do_bad(1'b1, 7'h11, 2'd1, 64'hFFFF_FFFF_FFFF_FFFF);
      do_load(7'h10, 2'd3, "R2");
      do_bad(1'b0, 7'h12, 2'd2, '0);
      do_bad(1'b1, 7'h14, 2'd3, 64'h0);
      do_load(7'h10, 2'd3, "R2");
      do_bad(1'b0, 7'h3F, 2'd1, '0);
   endtask

   task automatic t_busy_ignore;
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = 7'h20; req_size = 2'd3;
      req_wdata = 64'h1111_2222_3333_4444;
      @(negedge clk);
      chk("R9", "busy set", 64'(busy), 64'd1);
      req_addr = 7'h28; req_wdata = 64'h9999_8888_7777_6666;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
      ref_store(7'h20, 2'd3, 64'h1111_2222_3333_4444);
      chk("R8", "first store rsp", 64'(rsp_valid), 64'd1);
      @(negedge clk);
      chk("R9", "no second rsp", 64'(rsp_valid), 64'd0);
      chk("R9", "no second busy", 64'(busy), 64'd0);
      do_load(7'h28, 2'd3, "R9");
      do_load(7'h20, 2'd3, "R8");
   endtask

   task automatic t_back_to_back;
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = 7'h38; req_size = 2'd1;
      @(negedge clk);
      chk("R10", "first load", rsp_rdata, ref_load(7'h38, 2'd1));
      chk("R10", "first valid", 64'(rsp_valid), 64'd1);
      req_addr = 7'h3E;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R10", "second load", rsp_rdata, ref_load(7'h3E, 2'd1));
      chk("R10", "second valid", 64'(rsp_valid), 64'd1);
      @(negedge clk);
      chk("R10", "pulse ends", 64'(rsp_valid), 64'd0);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc >= LIMIT && !finished) begin
         finished = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual=%0d expected<%0d cycles", cyc, LIMIT);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < NWORDS; i++) ref_mem[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_split();
      t_lanes();
      t_partial();
      t_misalign();
      t_busy_ignore();
      t_back_to_back();
      if (!finished) begin
         finished = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule